// File: doc/BRIEF.md
# Set-Message Conformance Test Sequencer

This block is a hardware controller that checks an implementation Mealy machine against a specification. The specification is held as two parameter tables inside the block: one gives the next state and one gives the output for every (state, input) pair. The machine under test is reached through a command/response token interface. The controller sends one message, then waits for the response-valid handshake before it sends the next.

For every pair, the controller applies four messages in a fixed order:

1. a reset message;
2. a set message that carries the state index;
3. the input itself;
4. a status query.

The response to the input message is compared with the expected output. The state index returned by the status query is compared with the expected next state. A mismatch in the first comparison is an output fault. A mismatch in the second is a transfer fault.

A start pulse begins a run. The first fault ends it. When the run ends, the controller reports the following, and holds these results until the next start:

- pass or fail;
- the fault kind;
- the failing pair;
- the number of messages that completed.

Top module: `conf_seq_tester`

## Requirements
- R1: For each pair, messages go out in the order reset, set, apply, status. The `cmd_kind` encoding is 0 for reset, 1 for set, 2 for apply and 3 for status. `cmd_arg` carries the state index for a set, the input index for an apply, and zero for the other two kinds.
- R2: Pairs are visited from (0,0) onward. The state index is the outer loop and the input index is the inner loop.
- R3: If the response to an apply message differs from the zero-extended expected output, the controller stops with `done`=1, `pass`=0 and `fault_type`=0. It reports the pair on `fail_state` and `fail_input`.
- R4: If the response to a status message differs from the zero-extended expected next-state index, the controller stops with `done`=1, `pass`=0 and `fault_type`=1. It reports the pair on `fail_state` and `fail_input`.
- R5: When every pair matches, the run ends with `done`=1, `pass`=1 and `msg_count` equal to 4·N_STATES·N_INPUTS. Exactly that many commands are issued.
- R6: Each `cmd_valid` pulse lasts one cycle. No further command is issued until `resp_valid` arrives. A `resp_valid` received while no command is outstanding has no effect.
- R7: The first fault ends the run, and no command follows it. For a fault at pair k = s·N_INPUTS + a, `msg_count` is 4k+3 for an output fault and 4k+4 for a transfer fault.
- R8: The results stay unchanged until the next `start`. One cycle after a `start` pulse, `done` is 0 and `busy` is 1.
- R9: During and just after reset, `cmd_valid`, `busy`, `done` and `pass` are 0, and `msg_count` is 0.
- R10: Response data that returns for reset and set messages does not affect the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a run |
| cmd_valid | output | 1 | One-cycle message strobe to the machine under test |
| cmd_kind | output | 2 | Message kind: 0 reset, 1 set, 2 apply, 3 status |
| cmd_arg | output | AW | State index for set, input index for apply, otherwise 0 |
| resp_valid | input | 1 | Response handshake from the machine under test |
| resp_data | input | RW | Output symbol (apply) or state index (status) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The run has ended |
| pass | output | 1 | Every pair conformed |
| fault_type | output | 1 | 0 for an output fault, 1 for a transfer fault |
| fail_state | output | SW | State index of the failing pair |
| fail_input | output | IW | Input index of the failing pair |
| msg_count | output | CW | Number of messages that completed |

## Verification
The bench builds the block with three states, two inputs and a 2-bit output. The specification is computed by formula: next = (s+1+a) mod 3 and out = (2s+3a+1) mod 4. With only six pairs, the bench can inject an output fault and a transfer fault at every pair in turn. This checks the failing pair, the fault kind and the message count of each stopping point. A behavioural model answers with a latency that rotates through one to three cycles, and returns junk data for reset and set messages. Spurious handshakes sent while the controller is idle test that the held results do not move.

// File: rtl/conf_seq_pkg.sv
// Package: shared types for the conformance test sequencer.
// Assumes: message kinds are encoded in two bits and decoded by the machine under test.
package conf_seq_pkg;

    typedef enum logic [1:0] {
        MSG_RESET  = 2'd0,
        MSG_SET    = 2'd1,
        MSG_APPLY  = 2'd2,
        MSG_STATUS = 2'd3
    } msg_kind_t;

    typedef enum logic {
        FLT_OUTPUT   = 1'b0,
        FLT_TRANSFER = 1'b1
    } fault_kind_t;

    typedef enum logic [1:0] {
        E_IDLE  = 2'd0,
        E_ISSUE = 2'd1,
        E_WAIT  = 2'd2,
        E_END   = 2'd3
    } eng_state_t;

endpackage

// File: rtl/cts_spec_table.sv
// Module: cts_spec_table
// Unpacks the flattened specification tables into per-pair entries.
// It then returns the expected next state and output for the pair being tested.
// Assumes: entry index = state*N_INPUTS + input, and entry i sits at bits [i*width +: width].
module cts_spec_table #(
    parameter int N_STATES = 3,
    parameter int N_INPUTS = 2,
    parameter int OUT_W    = 2,
    parameter int SW       = 2,
    parameter int IW       = 1,
    parameter logic [N_STATES*N_INPUTS*SW-1:0]    SPEC_NEXT = '0,
    parameter logic [N_STATES*N_INPUTS*OUT_W-1:0] SPEC_OUT  = '0
) (
    input  logic [SW-1:0]    cur_state,
    input  logic [IW-1:0]    cur_input,
    output logic [SW-1:0]    exp_next,
    output logic [OUT_W-1:0] exp_out
);
    localparam int ENTRIES = N_STATES * N_INPUTS;

    logic [SW-1:0]    next_tab [ENTRIES];
    logic [OUT_W-1:0] out_tab  [ENTRIES];
    int               pair_idx;

    // Slice each table entry out of the parameter vectors.
    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_entry
        assign next_tab[gi] = SPEC_NEXT[gi*SW +: SW];
        assign out_tab[gi]  = SPEC_OUT[gi*OUT_W +: OUT_W];
    end

    // Look up the expected values for the current pair.
    always_comb begin
        pair_idx = int'(cur_state) * N_INPUTS + int'(cur_input);
        if (pair_idx < ENTRIES) begin
            exp_next = next_tab[pair_idx];
            exp_out  = out_tab[pair_idx];
        end else begin
            exp_next = '0;
            exp_out  = '0;
        end
    end

endmodule

// File: rtl/cts_pair_walker.sv
// Module: cts_pair_walker
// Steps through (state, input) pairs, with the state in the outer loop and the input in the inner loop.
// Assumes: step is never raised on the last pair; clear has priority over step.
module cts_pair_walker #(
    parameter int N_STATES = 3,
    parameter int N_INPUTS = 2,
    parameter int SW       = 2,
    parameter int IW       = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    output logic [SW-1:0] cur_state,
    output logic [IW-1:0] cur_input,
    output logic          last_pair
);
    localparam logic [SW-1:0] S_MAX = SW'(N_STATES - 1);
    localparam logic [IW-1:0] I_MAX = IW'(N_INPUTS - 1);

    // Advance the pair indices, wrapping the input index into the next state.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cur_state <= '0;
            cur_input <= '0;
        end else if (step) begin
            if (cur_input == I_MAX) begin
                cur_input <= '0;
                cur_state <= cur_state + SW'(1);
            end else begin
                cur_input <= cur_input + IW'(1);
            end
        end
    end

    // Flag the final pair of the sweep.
    always_comb last_pair = (cur_state == S_MAX) && (cur_input == I_MAX);

    assert_state_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cur_state) < N_STATES && int'(cur_input) < N_INPUTS);

    assert_inner_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && cur_input == I_MAX) |=> (cur_input == '0 && cur_state != $past(cur_state)));

endmodule

// File: rtl/cts_msg_engine.sv
// Module: cts_msg_engine
// Issues the four messages for each pair and waits for each response.
// Compares the apply and status responses against the specification and captures the verdict.
// Assumes: at most one message is outstanding; resp_valid is only meaningful while waiting.
module cts_msg_engine
    import conf_seq_pkg::*;
#(
    parameter int N_STATES = 3,
    parameter int N_INPUTS = 2,
    parameter int OUT_W    = 2,
    parameter int SW       = 2,
    parameter int IW       = 1,
    parameter int AW       = 2,
    parameter int RW       = 2,
    parameter int CW       = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             resp_valid,
    input  logic [RW-1:0]    resp_data,
    input  logic [SW-1:0]    exp_next,
    input  logic [OUT_W-1:0] exp_out,
    input  logic [SW-1:0]    cur_state,
    input  logic [IW-1:0]    cur_input,
    input  logic             last_pair,
    output logic             walk_clear,
    output logic             walk_step,
    output logic             cmd_valid,
    output msg_kind_t        cmd_kind,
    output logic [AW-1:0]    cmd_arg,
    output logic             busy,
    output logic             done,
    output logic             pass,
    output logic             fault_type,
    output logic [SW-1:0]    fail_state,
    output logic [IW-1:0]    fail_input,
    output logic [CW-1:0]    msg_count
);
    localparam int TOTAL = 4 * N_STATES * N_INPUTS;

    eng_state_t eng_st;
    msg_kind_t  phase;
    logic       got_resp;
    logic       out_ok;
    logic       status_ok;

    // Decode the response events and the two comparisons.
    always_comb begin
        got_resp  = (eng_st == E_WAIT) && resp_valid;
        out_ok    = (resp_data == RW'(exp_out));
        status_ok = (resp_data == RW'(exp_next));
        walk_clear = start && (eng_st == E_IDLE || eng_st == E_END);
        walk_step  = got_resp && (phase == MSG_STATUS) && status_ok && !last_pair;
    end

    // Drive the command port from the phase and the current pair.
    always_comb begin
        cmd_valid = (eng_st == E_ISSUE);
        cmd_kind  = phase;
        unique case (phase)
            MSG_SET:   cmd_arg = AW'(cur_state);
            MSG_APPLY: cmd_arg = AW'(cur_input);
            default:   cmd_arg = '0;
        endcase
        busy = (eng_st == E_ISSUE) || (eng_st == E_WAIT);
    end

    // Sequence the messages, count completed ones and capture the verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_st     <= E_IDLE;
            phase      <= MSG_RESET;
            done       <= 1'b0;
            pass       <= 1'b0;
            fault_type <= 1'b0;
            fail_state <= '0;
            fail_input <= '0;
            msg_count  <= '0;
        end else begin
            unique case (eng_st)
                E_IDLE, E_END: begin
                    if (start) begin
                        eng_st     <= E_ISSUE;
                        phase      <= MSG_RESET;
                        done       <= 1'b0;
                        pass       <= 1'b0;
                        fault_type <= 1'b0;
                        fail_state <= '0;
                        fail_input <= '0;
                        msg_count  <= '0;
                    end
                end
                E_ISSUE: eng_st <= E_WAIT;
                E_WAIT: begin
                    if (resp_valid) begin
                        msg_count <= msg_count + CW'(1);
                        unique case (phase)
                            MSG_RESET: begin
                                phase  <= MSG_SET;
                                eng_st <= E_ISSUE;
                            end
                            MSG_SET: begin
                                phase  <= MSG_APPLY;
                                eng_st <= E_ISSUE;
                            end
                            MSG_APPLY: begin
                                if (!out_ok) begin
                                    eng_st     <= E_END;
                                    done       <= 1'b1;
                                    fault_type <= FLT_OUTPUT;
                                    fail_state <= cur_state;
                                    fail_input <= cur_input;
                                end else begin
                                    phase  <= MSG_STATUS;
                                    eng_st <= E_ISSUE;
                                end
                            end
                            MSG_STATUS: begin
                                if (!status_ok) begin
                                    eng_st     <= E_END;
                                    done       <= 1'b1;
                                    fault_type <= FLT_TRANSFER;
                                    fail_state <= cur_state;
                                    fail_input <= cur_input;
                                end else if (last_pair) begin
                                    eng_st <= E_END;
                                    done   <= 1'b1;
                                    pass   <= 1'b1;
                                end else begin
                                    phase  <= MSG_RESET;
                                    eng_st <= E_ISSUE;
                                end
                            end
                            default: eng_st <= E_IDLE;
                        endcase
                    end
                end
                default: eng_st <= E_IDLE;
            endcase
        end
    end

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    assert_hold_while_waiting_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_st == E_WAIT && !resp_valid) |=> (!cmd_valid && $stable(msg_count)));

    assert_set_follows_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == MSG_RESET) |=> ##0 (eng_st == E_WAIT && phase == MSG_SET) or
        (eng_st == E_WAIT && phase == MSG_RESET));

    assert_pass_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done) && pass) |-> (msg_count == CW'(TOTAL)));

    assert_no_cmd_after_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cmd_valid);

    assert_results_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(pass) && $stable(fault_type) &&
                              $stable(fail_state) && $stable(fail_input) && $stable(msg_count)));

endmodule

// File: rtl/conf_seq_tester.sv
// Module: conf_seq_tester (top)
// Set-message conformance test sequencer. For every (state, input) pair it drives reset, set, apply
// and status into the machine under test, and checks the output and next state against the parameter tables.
// Assumes: N_STATES >= 2 and N_INPUTS >= 2; the machine under test answers every message with resp_valid.
module conf_seq_tester #(
    parameter int N_STATES = 3,
    parameter int N_INPUTS = 2,
    parameter int OUT_W    = 2,
    localparam int SW = $clog2(N_STATES),
    localparam int IW = $clog2(N_INPUTS),
    localparam int AW = (SW > IW) ? SW : IW,
    localparam int RW = (OUT_W > SW) ? OUT_W : SW,
    localparam int CW = $clog2(4 * N_STATES * N_INPUTS + 1),
    parameter logic [N_STATES*N_INPUTS*SW-1:0]    SPEC_NEXT = 12'b01_00_00_10_10_01,
    parameter logic [N_STATES*N_INPUTS*OUT_W-1:0] SPEC_OUT  = 12'b00_01_10_11_00_01
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          cmd_valid,
    output logic [1:0]    cmd_kind,
    output logic [AW-1:0] cmd_arg,
    input  logic          resp_valid,
    input  logic [RW-1:0] resp_data,
    output logic          busy,
    output logic          done,
    output logic          pass,
    output logic          fault_type,
    output logic [SW-1:0] fail_state,
    output logic [IW-1:0] fail_input,
    output logic [CW-1:0] msg_count
);
    import conf_seq_pkg::*;

    logic [SW-1:0]    cur_state;
    logic [IW-1:0]    cur_input;
    logic             last_pair;
    logic             walk_clear;
    logic             walk_step;
    logic [SW-1:0]    exp_next;
    logic [OUT_W-1:0] exp_out;
    msg_kind_t        kind_int;

    cts_spec_table #(
        .N_STATES(N_STATES), .N_INPUTS(N_INPUTS), .OUT_W(OUT_W), .SW(SW), .IW(IW),
        .SPEC_NEXT(SPEC_NEXT), .SPEC_OUT(SPEC_OUT)
    ) u_table (
        .cur_state(cur_state), .cur_input(cur_input),
        .exp_next(exp_next), .exp_out(exp_out)
    );

    cts_pair_walker #(
        .N_STATES(N_STATES), .N_INPUTS(N_INPUTS), .SW(SW), .IW(IW)
    ) u_walker (
        .clk(clk), .rst_n(rst_n), .clear(walk_clear), .step(walk_step),
        .cur_state(cur_state), .cur_input(cur_input), .last_pair(last_pair)
    );

    cts_msg_engine #(
        .N_STATES(N_STATES), .N_INPUTS(N_INPUTS), .OUT_W(OUT_W),
        .SW(SW), .IW(IW), .AW(AW), .RW(RW), .CW(CW)
    ) u_engine (
        .clk(clk), .rst_n(rst_n), .start(start),
        .resp_valid(resp_valid), .resp_data(resp_data),
        .exp_next(exp_next), .exp_out(exp_out),
        .cur_state(cur_state), .cur_input(cur_input), .last_pair(last_pair),
        .walk_clear(walk_clear), .walk_step(walk_step),
        .cmd_valid(cmd_valid), .cmd_kind(kind_int), .cmd_arg(cmd_arg),
        .busy(busy), .done(done), .pass(pass), .fault_type(fault_type),
        .fail_state(fail_state), .fail_input(fail_input), .msg_count(msg_count)
    );

    // Present the message kind as a plain two-bit code.
    assign cmd_kind = logic'(kind_int[1]) ? {1'b1, kind_int[0]} : {1'b0, kind_int[0]};

    assert_idle_after_reset_R9: assert property (@(posedge clk)
        !rst_n |=> (!cmd_valid && !busy && !done && !pass && msg_count == '0));

endmodule

// File: tb/conf_seq_tester_bench.sv
// Bench: a behavioural machine under test with fault injection and rotating latency.
// It sweeps every pair for both fault kinds, with expected values computed from the formulas.
module conf_seq_tester_bench;
    localparam int N  = 3;
    localparam int P  = 2;
    localparam int OW = 2;
    localparam int SW = 2;
    localparam int IW = 1;
    localparam int AW = 2;
    localparam int RW = 2;
    localparam int CW = 5;

    function automatic int sp_next(int s, int a);
        return (s + 1 + a) % N;
    endfunction

    function automatic int sp_out(int s, int a);
        return (2 * s + 3 * a + 1) % 4;
    endfunction

    function automatic logic [N*P*SW-1:0] pack_next();
        logic [N*P*SW-1:0] v = '0;
        for (int s = 0; s < N; s++)
            for (int a = 0; a < P; a++)
                v[(s*P+a)*SW +: SW] = SW'(sp_next(s, a));
        return v;
    endfunction

    function automatic logic [N*P*OW-1:0] pack_out();
        logic [N*P*OW-1:0] v = '0;
        for (int s = 0; s < N; s++)
            for (int a = 0; a < P; a++)
                v[(s*P+a)*OW +: OW] = OW'(sp_out(s, a));
        return v;
    endfunction

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          cmd_valid;
    logic [1:0]    cmd_kind;
    logic [AW-1:0] cmd_arg;
    logic          resp_valid = 1'b0;
    logic [RW-1:0] resp_data = '0;
    logic          busy, done, pass, fault_type;
    logic [SW-1:0] fail_state;
    logic [IW-1:0] fail_input;
    logic [CW-1:0] msg_count;

    int compared = 0;
    int mismatched = 0;
    int f_mode = 0, f_s = 0, f_a = 0;
    int imp_state = 0, seq_idx = 0, seq_err = 0, cmds_seen = 0;
    int wait_cnt = 0, lat_rot = 0;
    logic [RW-1:0] pend = '0;
    logic spur_req = 1'b0;

    always #5 clk = ~clk;

    conf_seq_tester #(
        .N_STATES(N), .N_INPUTS(P), .OUT_W(OW),
        .SPEC_NEXT(pack_next()), .SPEC_OUT(pack_out())
    ) u_conf_seq_tester (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_arg(cmd_arg),
        .resp_valid(resp_valid), .resp_data(resp_data),
        .busy(busy), .done(done), .pass(pass), .fault_type(fault_type),
        .fail_state(fail_state), .fail_input(fail_input), .msg_count(msg_count)
    );

    task automatic chk(string req, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Machine under test: watches commands, checks their order, answers after 1..3 cycles.
    initial begin
        forever begin
            @(negedge clk);
            resp_valid = 1'b0;
            if (spur_req) begin
                resp_valid = 1'b1;
                resp_data  = '1;
                spur_req   = 1'b0;
            end
            if (wait_cnt > 0) begin
                wait_cnt--;
                if (wait_cnt == 0) begin
                    resp_valid = 1'b1;
                    resp_data  = pend;
                end
            end
            if (cmd_valid === 1'b1) begin
                int k, ek, earg, a, o, nx;
                cmds_seen++;
                k    = seq_idx / 4;
                ek   = seq_idx % 4;
                earg = (ek == 1) ? k / P : (ek == 2) ? k % P : 0;
                if (int'(cmd_kind) != ek || int'(cmd_arg) != earg) seq_err++;
                seq_idx++;
                case (cmd_kind)
                    2'd0: begin imp_state = 0; pend = '1; end
                    2'd1: begin imp_state = int'(cmd_arg); pend = 2'b10; end
                    2'd2: begin
                        a  = int'(cmd_arg);
                        o  = sp_out(imp_state, a);
                        nx = sp_next(imp_state, a);
                        if (f_mode == 1 && imp_state == f_s && a == f_a) o = o ^ 1;
                        if (f_mode == 2 && imp_state == f_s && a == f_a) nx = (nx + 1) % N;
                        imp_state = nx;
                        pend = RW'(o);
                    end
                    default: pend = RW'(imp_state);
                endcase
                wait_cnt = 1 + (lat_rot % 3);
                lat_rot++;
            end
        end
    end

    // One run with an optional injected fault (mode 0 none, 1 output, 2 transfer).
    task automatic run_case(int mode, int s, int a);
        int k;
        f_mode = mode; f_s = s; f_a = a;
        seq_idx = 0; seq_err = 0; cmds_seen = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk("R8 done cleared by start", int'(done), 0);
        chk("R8 busy after start", int'(busy), 1);
        for (int i = 0; i < 3000 && done !== 1'b1; i++) @(negedge clk);
        repeat (8) @(negedge clk);
        k = s * P + a;
        chk("R1 R2 message order and arguments", seq_err, 0);
        chk("done at end of run", int'(done), 1);
        if (mode == 0) begin
            chk("R5 pass", int'(pass), 1);
            chk("R5 msg_count", int'(msg_count), 4 * N * P);
            chk("R5 commands issued", cmds_seen, 4 * N * P);
        end else begin
            chk(mode == 1 ? "R3 pass low" : "R4 pass low", int'(pass), 0);
            chk(mode == 1 ? "R3 fault_type" : "R4 fault_type", int'(fault_type), mode - 1);
            chk(mode == 1 ? "R3 fail_state" : "R4 fail_state", int'(fail_state), s);
            chk(mode == 1 ? "R3 fail_input" : "R4 fail_input", int'(fail_input), a);
            chk("R7 msg_count at stop", int'(msg_count), 4 * k + 2 + mode);
            chk("R7 no command after stop", cmds_seen, 4 * k + 2 + mode);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 cmd_valid in reset", int'(cmd_valid), 0);
        chk("R9 busy in reset", int'(busy), 0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk("R9 done after reset", int'(done), 0);
        chk("R9 pass after reset", int'(pass), 0);
        chk("R9 msg_count after reset", int'(msg_count), 0);
        chk("R9 cmd_valid after reset", int'(cmd_valid), 0);

        // R5 and R10: a clean run, with junk data returned for reset and set.
        run_case(0, 0, 0);

        // R3, R4 and R7: every pair, both fault kinds.
        for (int s = 0; s < N; s++)
            for (int a = 0; a < P; a++) begin
                run_case(1, s, a);
                run_case(2, s, a);
            end

        // R6 and R8: spurious handshakes while idle leave the held results unchanged.
        begin
            int h_pass, h_type, h_fs, h_fi, h_cnt, h_cmds;
            h_pass = int'(pass); h_type = int'(fault_type); h_fs = int'(fail_state);
            h_fi = int'(fail_input); h_cnt = int'(msg_count); h_cmds = cmds_seen;
            spur_req = 1'b1;
            repeat (6) @(negedge clk);
            chk("R6 no command from stray resp_valid", cmds_seen, h_cmds);
            chk("R8 msg_count held", int'(msg_count), h_cnt);
            chk("R8 fault_type held", int'(fault_type), h_type);
            chk("R8 fail_state held", int'(fail_state), h_fs);
            chk("R8 fail_input held", int'(fail_input), h_fi);
            chk("R8 pass held", int'(pass), h_pass);
            chk("R8 done held", int'(done), 1);
        end

        // R8: a fresh start after a failure clears the verdict and runs clean.
        run_case(0, 0, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule